// File: doc/BRIEF.md
# Polled Two-Level Interrupt Controller

This block arbitrates interrupt requests for a processor core that runs in machine cycles. Once per machine cycle, on a strobe from the core, it captures the raw request flags. At the next strobe it polls the captured flags against the per-source enables, the global enable and the per-source priority level. If nothing blocks the poll, it issues a call request together with a vector address. That call request stands for the hardware-generated subroutine call into the service routine.

A poll is refused in three cases: a routine of equal or higher level is already in service; the core is not in the final cycle of its instruction; or the instruction is a return-from-interrupt or a write to the interrupt control registers. A refused request is not kept. The next poll sees only the flags captured at the strobe just before it.

On each grant the block pulses one acknowledge line, so the chosen source can clear its own flag. It also marks the granted level as in service. Only a return-from-interrupt indication clears that mark.

Top module: `irq_poll_ctrl`

## Requirements
- R1: A request present at one strobe edge is captured there and can lead to a call only at the following strobe edge. No call starts at the capturing edge itself.
- R2: On a grant, `vec_o` becomes 0x0003 + 8 × (source index). `ack_o` carries a one-hot bit at the source index for exactly one clock, starting on the same clock that `call_o` rises.
- R3: `prio_i[i]` = 1 puts source i on the high level. A pending high-level source wins over any low-level source. Within one level, the lower index wins.
- R4: A source whose `en_i` bit is 0 is never granted. When `glb_en_i` is 0, no source is granted.
- R5: A poll strobe with `last_cyc_i` = 0 grants nothing.
- R6: A poll strobe with `reti_i` = 1 or `irq_wr_i` = 1 grants nothing.
- R7: A request refused at one poll and absent at the next capture is never serviced later.
- R8: While the low level is in service (`act_o[0]` = 1), low-level sources are refused and high-level sources may still be granted. While the high level is in service (`act_o[1]` = 1), every source is refused.
- R9: `act_o[1]` (high level) and `act_o[0]` (low level) are set by a grant at that level. They are cleared only by a strobe with `reti_i` = 1, which clears the high bit if it is set and otherwise the low bit.
- R10: `call_o` stays high from the grant until the second strobe after the grant, so it spans two machine cycles.
- R11: After reset, `call_o`, `ack_o` and `act_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mcyc_i | input | 1 | Machine-cycle strobe, one clock wide |
| req_i | input | NSRC | Raw request flags |
| en_i | input | NSRC | Per-source enable |
| prio_i | input | NSRC | Per-source level, 1 = high |
| glb_en_i | input | 1 | Global enable |
| last_cyc_i | input | 1 | Core is in the final cycle of its instruction |
| reti_i | input | 1 | Current instruction is return-from-interrupt |
| irq_wr_i | input | 1 | Current instruction writes enable or priority registers |
| call_o | output | 1 | Call request to the core |
| vec_o | output | VEC_W | Vector address of the granted source |
| ack_o | output | NSRC | One-clock acknowledge, one-hot at the granted source |
| act_o | output | 2 | In-service flags, bit 1 high level, bit 0 low level |

## Verification
Responses are counted in strobes, not clocks. A flag captured at strobe k can raise `call_o`, `vec_o` and `ack_o` one clock after strobe k+1, and the bench samples them on the falling edge just after that strobe. The in-service flags change on the same grant or return strobe and are read at that same falling edge. `call_o` is checked high after the next strobe and low after the second one. After each scenario the bench lets two idle machine cycles pass, so that a call which is late, or a refused request that wrongly resurfaces, is caught as an unexpected call.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;
  typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} lvl_e;
  localparam int unsigned NUM_LVL = 2;
endpackage

// File: rtl/irq_penc.sv
module irq_penc #(
  parameter int unsigned N     = 5,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  assign any_o = |vec_i;

  // lowest set index wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_poll_pkg::*;
#(
  parameter int unsigned N     = 5,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]                    cand_i,
  input  logic [N-1:0]                    prio_i,
  output logic [NUM_LVL-1:0]              any_o,
  output logic [NUM_LVL-1:0][IDX_W-1:0]   idx_o
);
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    logic [N-1:0] lvl_cand;
    if (g == int'(LVL_HI)) begin : g_hi
      assign lvl_cand = cand_i & prio_i;
    end else begin : g_lo
      assign lvl_cand = cand_i & ~prio_i;
    end
    irq_penc #(.N(N), .IDX_W(IDX_W)) penc_i (
      .vec_i (lvl_cand),
      .any_o (any_o[g]),
      .idx_o (idx_o[g])
    );
  end
endmodule

// File: rtl/irq_inserv.sv
module irq_inserv
  import irq_poll_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_i,
  input  lvl_e               set_lvl_i,
  input  logic               clr_i,
  output logic [NUM_LVL-1:0] act_o
);
  logic [NUM_LVL-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
    end else begin
      if (clr_i) begin
        if (act_q[LVL_HI]) act_q[LVL_HI] <= 1'b0;
        else               act_q[LVL_LO] <= 1'b0;
      end
      if (set_i) act_q[set_lvl_i] <= 1'b1;
    end
  end

  assign act_o = act_q;

  // R9
  lo_clr_only_reti_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q[LVL_LO]) |-> $past(clr_i));
  // R9
  hi_clr_only_reti_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q[LVL_HI]) |-> $past(clr_i));
  // R9
  hi_first_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q[LVL_LO]) |-> !$past(act_q[LVL_HI]));
endmodule

// File: rtl/irq_poll_ctrl.sv
module irq_poll_ctrl
  import irq_poll_pkg::*;
#(
  parameter int unsigned NSRC     = 5,
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned VEC_STEP = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mcyc_i,
  input  logic [NSRC-1:0]    req_i,
  input  logic [NSRC-1:0]    en_i,
  input  logic [NSRC-1:0]    prio_i,
  input  logic               glb_en_i,
  input  logic               last_cyc_i,
  input  logic               reti_i,
  input  logic               irq_wr_i,
  output logic               call_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [NSRC-1:0]    ack_o,
  output logic [1:0]         act_o
);
  localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]                   smp_q;
  logic [NSRC-1:0]                   cand;
  logic [NUM_LVL-1:0]                lvl_any;
  logic [NUM_LVL-1:0][IDX_W-1:0]     lvl_idx;
  logic [NUM_LVL-1:0]                act;
  logic                              call_q, call_cnt_q;
  logic [VEC_W-1:0]                  vec_q;
  logic [NSRC-1:0]                   ack_q;
  logic                              poll_ok, take_hi, take_lo, grant;
  lvl_e                              grant_lvl;
  logic [IDX_W-1:0]                  grant_idx;

  // capture once per machine cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     smp_q <= '0;
    else if (mcyc_i) smp_q <= req_i;
  end

  assign cand = smp_q & en_i & {NSRC{glb_en_i}};

  irq_arb #(.N(NSRC), .IDX_W(IDX_W)) arb_i (
    .cand_i (cand),
    .prio_i (prio_i),
    .any_o  (lvl_any),
    .idx_o  (lvl_idx)
  );

  assign poll_ok   = mcyc_i && last_cyc_i && !reti_i && !irq_wr_i && !call_q;
  assign take_hi   = lvl_any[LVL_HI] && !act[LVL_HI];
  assign take_lo   = !lvl_any[LVL_HI] && lvl_any[LVL_LO] && (act == '0);
  assign grant     = poll_ok && (take_hi || take_lo);
  assign grant_lvl = take_hi ? LVL_HI : LVL_LO;
  assign grant_idx = lvl_idx[grant_lvl];

  irq_inserv inserv_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (grant),
    .set_lvl_i (grant_lvl),
    .clr_i     (mcyc_i && reti_i),
    .act_o     (act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      call_q     <= 1'b0;
      call_cnt_q <= 1'b0;
      vec_q      <= '0;
      ack_q      <= '0;
    end else begin
      ack_q <= '0;
      if (grant) begin
        call_q     <= 1'b1;
        call_cnt_q <= 1'b0;
        vec_q      <= VEC_W'(VEC_BASE) + VEC_W'(grant_idx) * VEC_W'(VEC_STEP);
        ack_q      <= NSRC'(1) << grant_idx;
      end else if (call_q && mcyc_i) begin
        // call spans two machine cycles
        if (call_cnt_q) call_q <= 1'b0;
        call_cnt_q <= ~call_cnt_q;
      end
    end
  end

  assign call_o = call_q;
  assign vec_o  = vec_q;
  assign ack_o  = ack_q;
  assign act_o  = act;

  // R2
  ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o));
  // R2
  ack_with_call_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_o) |-> $rose(call_o));
  // R2
  vec_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_o |-> (vec_o % VEC_W'(VEC_STEP)) == VEC_W'(VEC_BASE % VEC_STEP));
  // R5
  grant_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(call_o) |-> $past(mcyc_i && last_cyc_i));
  // R6
  grant_noblk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(call_o) |-> $past(!reti_i && !irq_wr_i));
  // R10
  call_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(call_o) |=> call_o);
  // R8
  hi_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(act_o[1]) |-> !$rose(call_o));
endmodule

// File: tb/irq_poll_ctrl_tb_top.sv
module irq_poll_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC  = 5;
  localparam int VEC_W = 16;

  typedef struct {
    logic [VEC_W-1:0] vec;
    logic [NSRC-1:0]  ack;
    string            tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mcyc_i = 1'b0;
  logic [NSRC-1:0] req_i = '0, en_i = '1, prio_i = '0;
  logic glb_en_i = 1'b1, last_cyc_i = 1'b1, reti_i = 1'b0, irq_wr_i = 1'b0;
  logic call_o;
  logic [VEC_W-1:0] vec_o;
  logic [NSRC-1:0] ack_o;
  logic [1:0] act_o;

  int n_chk = 0, n_bad = 0;
  exp_t exp_q[$];
  logic call_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_poll_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mcyc_i(mcyc_i), .req_i(req_i), .en_i(en_i),
    .prio_i(prio_i), .glb_en_i(glb_en_i), .last_cyc_i(last_cyc_i),
    .reti_i(reti_i), .irq_wr_i(irq_wr_i), .call_o(call_o), .vec_o(vec_o),
    .ack_o(ack_o), .act_o(act_o)
  );

  task automatic chk(input logic ok, input string tag, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  // monitor: pops expected grants on each call start
  always @(negedge clk) begin
    if (rst_ni && call_o && !call_prev) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected call", int'(vec_o), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(vec_o == e.vec, {e.tag, " vector"}, int'(vec_o), int'(e.vec));
        chk(ack_o == e.ack, {e.tag, " ack"}, int'(ack_o), int'(e.ack));
      end
    end
    call_prev <= call_o;
  end

  task automatic strobe();
    mcyc_i = 1'b1;
    @(negedge clk);
    mcyc_i = 1'b0;
  endtask

  task automatic mcycle();
    strobe();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic push_exp(input int idx, input string tag);
    exp_t e;
    e.vec = VEC_W'(3 + 8 * idx);
    e.ack = NSRC'(1) << idx;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // capture req, poll with given blocking inputs, then drain
  task automatic run_case(input logic [NSRC-1:0] req, input logic last, input logic reti,
                          input logic wr, input int exp_idx, input string tag);
    req_i = req;
    strobe();
    chk(call_o == 1'b0, "R1 no call at capture", int'(call_o), 0);
    @(negedge clk); @(negedge clk);
    req_i = '0; last_cyc_i = last; reti_i = reti; irq_wr_i = wr;
    if (exp_idx >= 0) push_exp(exp_idx, tag);
    strobe();
    last_cyc_i = 1'b1; reti_i = 1'b0; irq_wr_i = 1'b0;
    if (exp_idx >= 0) begin
      chk(call_o == 1'b1, "R10 call up at grant", int'(call_o), 1);
      @(negedge clk); @(negedge clk);
      strobe();
      chk(call_o == 1'b1, "R10 call held one strobe later", int'(call_o), 1);
      @(negedge clk); @(negedge clk);
      strobe();
      chk(call_o == 1'b0, "R10 call down two strobes later", int'(call_o), 0);
    end else begin
      chk(call_o == 1'b0, {tag, " refused"}, int'(call_o), 0);
    end
    @(negedge clk); @(negedge clk);
    mcycle(); mcycle();
    chk(exp_q.size() == 0, {tag, " grant consumed"}, exp_q.size(), 0);
  endtask

  task automatic do_reti();
    reti_i = 1'b1;
    strobe();
    reti_i = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R11
    chk(call_o == 0 && ack_o == 0 && act_o == 0, "R11 reset state",
        int'({call_o, ack_o, act_o}), 0);

    // R2 low source 2 -> 19, R9 sets low bit
    run_case(5'b00100, 1, 0, 0, 2, "R2 low src2");
    chk(act_o == 2'b01, "R9 low in service", int'(act_o), 1);
    // R8 low refused while low in service
    run_case(5'b00001, 1, 0, 0, -1, "R8 low blocked by low");
    // R8 high allowed over low in service
    prio_i = 5'b11000;
    run_case(5'b10000, 1, 0, 0, 4, "R8 high over low src4");
    chk(act_o == 2'b11, "R9 both in service", int'(act_o), 3);
    run_case(5'b01000, 1, 0, 0, -1, "R8 high blocked by high");
    repeat (5) mcycle();
    chk(act_o == 2'b11, "R9 held without reti", int'(act_o), 3);
    do_reti();
    chk(act_o == 2'b01, "R9 reti clears high first", int'(act_o), 1);
    do_reti();
    chk(act_o == 2'b00, "R9 reti clears low", int'(act_o), 0);

    // R3 within level, lower index wins
    prio_i = 5'b00000;
    run_case(5'b01010, 1, 0, 0, 1, "R3 lower index src1");
    do_reti();
    // R3 high level wins over lower-index low source
    prio_i = 5'b01000;
    run_case(5'b01001, 1, 0, 0, 3, "R3 high level src3");
    do_reti();
    chk(act_o == 2'b00, "R9 cleared after high", int'(act_o), 0);

    // R4 enables
    prio_i = '0;
    en_i = 5'b11011;
    run_case(5'b00100, 1, 0, 0, -1, "R4 source disabled");
    en_i = '1; glb_en_i = 1'b0;
    run_case(5'b00010, 1, 0, 0, -1, "R4 global disabled");
    glb_en_i = 1'b1;

    // R5 / R6 / R7 blocks, then request forgotten
    run_case(5'b00010, 0, 0, 0, -1, "R5 not final cycle");
    run_case(5'b00010, 1, 1, 0, -1, "R6 reti in progress");
    run_case(5'b00001, 1, 0, 1, -1, "R6 interrupt register write");
    chk(act_o == 2'b00, "R7 nothing serviced after blocks", int'(act_o), 0);

    // R2 source 0 -> 3
    run_case(5'b00001, 1, 0, 0, 0, "R2 src0 base vector");
    do_reti();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule